// File: doc/BRIEF.md
# Routed Interrupt Aggregation Controller

This block gathers a vector of level-sensitive interrupt sources and steers each one to a single processor core and to one of four interrupt lines on that core. Each source has a raw status bit that follows its input level and an enable bit. A source counts as pending for its core while both bits are set. Every (core, line) output is the OR of the pending sources routed to that pair. Because of this, an output rises with the first routed pending source and falls only when the last one clears.

Routing comes from two tables. A line table holds one byte per group of 32 sources, and a core table holds one byte per source. Table bytes arrive as decoded write strobes, and enable bits arrive one source per write. Two mode inputs choose how the bytes are read. In mask mode, the lowest set bit gives the index. In index mode, the byte is a plain number. A core byte is decoded once, when it is written. A line byte is decoded continuously under the current line mode. When a routing change, an enable change or a level change affects a source that is still pending, the outputs move that source in the same cycle.

Top module: `irq_route_agg`

## Requirements
- R1: In mask mode (`line_idx_mode`=0), a group's line is the position of the lowest set bit of its line byte. An all-zero byte, or a position of 4 or more, selects line 0. A line byte written through `lmap_we` is used from the next cycle.
- R2: In index mode (`line_idx_mode`=1), a group's line is bits [1:0] of its line byte.
- R3: In mask mode (`core_idx_mode`=0), a written core byte selects the core at the position of its lowest set bit. A position of 4 or more selects core 0. An all-zero byte is ignored, and the previous route is kept.
- R4: In index mode (`core_idx_mode`=1), a core byte selects the core given by its value. A decoded core of `N_CORE` or more, in either mode, is ignored, and the previous route is kept.
- R5: `irq_out` bit c*4+l is 1 exactly when at least one source has its level high, its enable bit set, its route equal to core c and its group line equal to l.
- R6: An enable write of 1 to a source whose level is high raises that source on its routed output. An enable write of 0 lowers it.
- R7: A core byte that changes the route of a pending source moves it from the old core's output to the new one. A write that decodes to the current core leaves every output unchanged.
- R8: Outputs come from registers. A change sampled at a clock edge shows on `irq_out` after that edge and not before it. A table write and a level change in the same cycle both take effect at that one edge.
- R9: After reset, `irq_out` is zero, all enable bits are 0, every source routes to core 0, and every line byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_level | input | N_SRC | Source levels, one bit per source |
| line_idx_mode | input | 1 | 1: line bytes are indices; 0: lowest-set-bit masks |
| core_idx_mode | input | 1 | 1: core bytes are indices; 0: lowest-set-bit masks |
| lmap_we | input | 1 | Line-table byte write strobe |
| lmap_idx | input | GW | Group number for the line-table write |
| lmap_data | input | 8 | Line-table byte |
| cmap_we | input | 1 | Core-table byte write strobe |
| cmap_idx | input | IW | Source number for the core-table write |
| cmap_data | input | 8 | Core-table byte |
| en_we | input | 1 | Enable-bit write strobe |
| en_idx | input | IW | Source number for the enable write |
| en_val | input | 1 | New enable value |
| irq_out | output | N_CORE*4 | Aggregated outputs, bit c*4+l for core c, line l |

## Verification
The assertions assume that write indices stay inside the configured source and group counts. They also assume the mode inputs change only between writes, since a core byte is decoded under the mode that applies when it is written. The stimulus draws every index from the valid range. It changes modes only as a separate step, so the table vectors and the random phase never pair a mode change with a core write. Ignored core bytes appear only as an all-zero mask or as index values of `N_CORE` and above, which the assertions expect to leave the route unchanged.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int GRP_SIZE  = 32;
   localparam int LINES     = 4;
   localparam int BYTE_W    = 8;

   // Position of the lowest set bit; 8 when the byte is zero.
   function automatic logic [3:0] low_bit_pos(input logic [BYTE_W-1:0] b);
      logic [3:0] p;
      p = 4'd8;
      for (int k = BYTE_W - 1; k >= 0; k--) begin
         if (b[k]) p = 4'(k);
      end
      return p;
   endfunction

endpackage

// File: rtl/irq_line_map.sv
module irq_line_map
   import irq_route_pkg::*;
#(
   parameter int N_GRP = 2,
   parameter int GW    = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [GW-1:0]           idx,
   input  logic [BYTE_W-1:0]       data,
   input  logic                    idx_mode,
   output logic [N_GRP-1:0][1:0]   grp_line
);

   logic [N_GRP-1:0][BYTE_W-1:0] tbl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbl_q <= '0;
      else if (we) tbl_q[idx] <= data;
   end

   // Line bytes are decoded live, under the current mode.
   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic [3:0] pos;
      always_comb begin
         pos = low_bit_pos(tbl_q[g]);
         if (idx_mode)     grp_line[g] = tbl_q[g][1:0];
         else if (pos < 4) grp_line[g] = pos[1:0];
         else              grp_line[g] = 2'd0;
      end
   end

   assert_line_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> tbl_q[$past(idx)] == $past(data));

endmodule

// File: rtl/irq_core_route.sv
module irq_core_route
   import irq_route_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int N_CORE = 4,
   parameter int IW     = 6,
   parameter int CW     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IW-1:0]              idx,
   input  logic [BYTE_W-1:0]          data,
   input  logic                       idx_mode,
   output logic [N_SRC-1:0][CW-1:0]   route_q
);

   localparam logic [BYTE_W-1:0] NC8 = BYTE_W'(N_CORE);

   logic [3:0]        pos;
   logic [BYTE_W-1:0] cand;
   logic              ok;

   // Core bytes are decoded once, at write time.
   always_comb begin
      pos  = low_bit_pos(data);
      cand = '0;
      ok   = 1'b0;
      if (idx_mode) begin
         cand = data;
         ok   = data < NC8;
      end else if (pos != 4'd8) begin
         cand = (pos >= 4) ? '0 : {4'd0, pos};
         ok   = cand < NC8;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        route_q <= '0;
      else if (we && ok) route_q[idx] <= cand[CW-1:0];
   end

   assert_bad_core_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !ok) |=> route_q[$past(idx)] == $past(route_q[idx]));

   assert_zero_mask_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !idx_mode && data == '0) |=> $stable(route_q));

endmodule

// File: rtl/irq_aggregate.sv
module irq_aggregate
   import irq_route_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int N_CORE = 4,
   parameter int N_GRP  = 2,
   parameter int CW     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_SRC-1:0]           pend,
   input  logic [N_SRC-1:0][CW-1:0]   route,
   input  logic [N_GRP-1:0][1:0]      grp_line,
   output logic [N_CORE*LINES-1:0]    irq
);

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      for (genvar l = 0; l < LINES; l++) begin : g_line
         logic [N_SRC-1:0] hit;
         always_comb begin
            for (int i = 0; i < N_SRC; i++) begin
               hit[i] = pend[i] && (route[i] == CW'(c))
                        && (grp_line[i / GRP_SIZE] == 2'(l));
            end
         end
         assign irq[c*LINES + l] = |hit;
      end
   end

   // Each pending source drives exactly one output bit.
   assert_no_extra_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(irq) <= $countones(pend));

endmodule

// File: rtl/irq_route_agg.sv
module irq_route_agg
   import irq_route_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int N_CORE = 4,
   localparam int N_GRP = N_SRC / GRP_SIZE,
   localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1,
   localparam int CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_SRC-1:0]          src_level,
   input  logic                      line_idx_mode,
   input  logic                      core_idx_mode,
   input  logic                      lmap_we,
   input  logic [GW-1:0]             lmap_idx,
   input  logic [BYTE_W-1:0]         lmap_data,
   input  logic                      cmap_we,
   input  logic [IW-1:0]             cmap_idx,
   input  logic [BYTE_W-1:0]         cmap_data,
   input  logic                      en_we,
   input  logic [IW-1:0]             en_idx,
   input  logic                      en_val,
   output logic [N_CORE*LINES-1:0]   irq_out
);

   if (N_SRC % GRP_SIZE != 0 || N_SRC < GRP_SIZE) begin : g_bad_src
      $error("N_SRC must be a positive multiple of 32");
   end
   if (N_CORE < 1 || N_CORE > 8) begin : g_bad_core
      $error("N_CORE must lie in 1..8");
   end

   logic [N_SRC-1:0]           raw_q;
   logic [N_SRC-1:0]           en_q;
   logic [N_SRC-1:0][CW-1:0]   route_q;
   logic [N_GRP-1:0][1:0]      grp_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         en_q  <= '0;
      end else begin
         raw_q <= src_level;
         if (en_we) en_q[en_idx] <= en_val;
      end
   end

   irq_line_map #(.N_GRP(N_GRP), .GW(GW)) u_line (
      .clk(clk), .rst_n(rst_n), .we(lmap_we), .idx(lmap_idx),
      .data(lmap_data), .idx_mode(line_idx_mode), .grp_line(grp_line));

   irq_core_route #(.N_SRC(N_SRC), .N_CORE(N_CORE), .IW(IW), .CW(CW)) u_route (
      .clk(clk), .rst_n(rst_n), .we(cmap_we), .idx(cmap_idx),
      .data(cmap_data), .idx_mode(core_idx_mode), .route_q(route_q));

   irq_aggregate #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_GRP(N_GRP), .CW(CW)) u_agg (
      .clk(clk), .rst_n(rst_n), .pend(raw_q & en_q), .route(route_q),
      .grp_line(grp_line), .irq(irq_out));

   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_level == '0) |=> (irq_out == '0));

   assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> (irq_out == '0));

   assert_drop_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_we && !en_val && en_q == '0) |=> (irq_out == '0));

endmodule

// File: tb/irq_route_agg_bench.sv
module irq_route_agg_bench;

   localparam int NS = 64;
   localparam int NC = 4;
   localparam int OW = NC * 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_level = '0;
   logic          line_idx_mode = 1'b0, core_idx_mode = 1'b0;
   logic          lmap_we = 1'b0, cmap_we = 1'b0, en_we = 1'b0, en_val = 1'b0;
   logic [0:0]    lmap_idx = '0;
   logic [5:0]    cmap_idx = '0, en_idx = '0;
   logic [7:0]    lmap_data = '0, cmap_data = '0;
   logic [OW-1:0] irq_out;

   always #2 clk = ~clk;

   irq_route_agg #(.N_SRC(NS), .N_CORE(NC)) u_irq_route_agg (
      .clk(clk), .rst_n(rst_n), .src_level(src_level),
      .line_idx_mode(line_idx_mode), .core_idx_mode(core_idx_mode),
      .lmap_we(lmap_we), .lmap_idx(lmap_idx), .lmap_data(lmap_data),
      .cmap_we(cmap_we), .cmap_idx(cmap_idx), .cmap_data(cmap_data),
      .en_we(en_we), .en_idx(en_idx), .en_val(en_val), .irq_out(irq_out));

   int errors = 0, checks = 0;
   bit done = 0;

   // Reference state
   bit       m_en [NS];
   int       m_route [NS];
   bit [7:0] m_lmap [2];

   function automatic int low_pos(bit [7:0] b);
      for (int k = 0; k < 8; k++) if (b[k]) return k;
      return 8;
   endfunction

   function automatic int m_line(int g);
      int p;
      if (line_idx_mode) return int'(m_lmap[g][1:0]);
      p = low_pos(m_lmap[g]);
      return (p < 4) ? p : 0;
   endfunction

   function automatic logic [OW-1:0] m_irq();
      logic [OW-1:0] r = '0;
      for (int i = 0; i < NS; i++)
         if (src_level[i] && m_en[i]) r[m_route[i]*4 + m_line(i/32)] = 1'b1;
      return r;
   endfunction

   task automatic m_cmap(int i, bit [7:0] d);
      int cand, p;
      if (core_idx_mode) cand = int'(d);
      else begin
         p = low_pos(d);
         if (p == 8) return;
         cand = (p >= 4) ? 0 : p;
      end
      if (cand < NC) m_route[i] = cand;
   endtask

   task automatic m_reset();
      for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_route[i] = 0; end
      m_lmap[0] = '0; m_lmap[1] = '0;
   endtask

   task automatic check(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq_out actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      lmap_we = 0; cmap_we = 0; en_we = 0;
   endtask

   // op: 0 level, 1 enable, 2 core byte, 3 line byte, 4 modes {core,line}
   task automatic apply_op(int op, int idx, bit [7:0] d);
      case (op)
         0: src_level[idx] = d[0];
         1: begin en_we = 1; en_idx = 6'(idx); en_val = d[0]; m_en[idx] = d[0]; end
         2: begin cmap_we = 1; cmap_idx = 6'(idx); cmap_data = d; m_cmap(idx, d); end
         3: begin lmap_we = 1; lmap_idx = 1'(idx); lmap_data = d; m_lmap[idx] = d; end
         default: begin line_idx_mode = d[0]; core_idx_mode = d[1]; end
      endcase
      tick();
   endtask

   // {op, idx, data, expected irq_out}
   localparam logic [35:0] VEC [20] = '{
      {4'd0, 8'd3,  8'h01, 16'h0000},
      {4'd1, 8'd3,  8'h01, 16'h0001},
      {4'd2, 8'd3,  8'h04, 16'h0100},
      {4'd3, 8'd0,  8'h08, 16'h0800},
      {4'd0, 8'd40, 8'h01, 16'h0800},
      {4'd1, 8'd40, 8'h01, 16'h0801},
      {4'd2, 8'd40, 8'h00, 16'h0801},
      {4'd2, 8'd40, 8'h30, 16'h0801},
      {4'd2, 8'd40, 8'h82, 16'h0810},
      {4'd3, 8'd1,  8'h20, 16'h0810},
      {4'd1, 8'd3,  8'h00, 16'h0010},
      {4'd0, 8'd40, 8'h00, 16'h0000},
      {4'd1, 8'd3,  8'h01, 16'h0800},
      {4'd4, 8'd0,  8'h02, 16'h0800},
      {4'd2, 8'd3,  8'h07, 16'h0800},
      {4'd2, 8'd3,  8'h01, 16'h0080},
      {4'd4, 8'd0,  8'h03, 16'h0010},
      {4'd3, 8'd0,  8'h06, 16'h0040},
      {4'd4, 8'd0,  8'h00, 16'h0020},
      {4'd2, 8'd3,  8'h02, 16'h0020}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      check("R9 reset outputs", irq_out, '0);
      rst_n = 1;
      @(negedge clk);

      // Table: R1 R2 R3 R4 R5 R6 R7 (one-hot, index and ignored bytes)
      foreach (VEC[v]) begin
         apply_op(int'(VEC[v][35:32]), int'(VEC[v][31:24]), VEC[v][23:16]);
         check($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", v), irq_out, VEC[v][15:0]);
      end

      // Random phase against the reference model (R5)
      for (int n = 0; n < 400; n++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op >= 5) op = (op == 9) ? 4 : op - 5;
         case (op)
            0, 1:    apply_op(op, int'($urandom_range(0, NS-1)), 8'($urandom_range(0, 1)));
            2:       apply_op(op, int'($urandom_range(0, NS-1)), 8'($urandom_range(0, 255)));
            3:       apply_op(op, int'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
            default: apply_op(op, 0, 8'($urandom_range(0, 3)));
         endcase
         check("R5 random", irq_out, m_irq());
      end

      // Mid-run reset (R9): route core 0, line byte zero -> line 0
      rst_n = 0; src_level = '0; line_idx_mode = 0; core_idx_mode = 0;
      m_reset();
      @(negedge clk);
      check("R9 reset mid-run", irq_out, '0);
      rst_n = 1;
      @(negedge clk);
      apply_op(0, 0, 8'h01);
      check("R9 enable cleared by reset", irq_out, '0);
      apply_op(1, 0, 8'h01);
      check("R9 default route core0 line0", irq_out, 16'h0001);

      // R8: no change before the sampling edge
      apply_op(1, 2, 8'h01);
      src_level[2] = 1'b1;
      #1;
      check("R8 before edge", irq_out, 16'h0001);
      tick();
      check("R8 after edge", irq_out, 16'h0001);

      // R8: core write and level rise in one cycle (src 5 enabled, to core 3)
      apply_op(1, 5, 8'h01);
      cmap_we = 1; cmap_idx = 6'd5; cmap_data = 8'h08; m_cmap(5, 8'h08);
      src_level[5] = 1'b1;
      tick();
      check("R8 simultaneous write and level", irq_out, 16'h1001);

      // R7: rewrite to the same core keeps outputs
      apply_op(2, 5, 8'h18);
      check("R7 same core no change", irq_out, 16'h1001);

      // R6: disable the last pending on core 3
      apply_op(1, 5, 8'h00);
      check("R6 disable lowers", irq_out, 16'h0001);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule